// File: doc/BRIEF.md
# PHY Ready Timeout Watchdog

This block guards a serial link against a physical layer that has lost readiness and does not recover. It runs on the transmit word clock and watches a PHY-ready level. While the watchdog is enabled and readiness is low, it counts clock edges down from a reload value. The reload value is the 10-bit timeout field shifted left by nine bits, so one step of the field is 512 words. When the count runs out, the block raises a one-cycle PHY-reset request so that link bring-up can start again.

The field and the enable come from a configuration register that lies outside this block. A controller state machine drives a loadable down-counter. Its four states are `ST_OFF` (disabled), `ST_WATCH` (enabled, PHY ready), `ST_COUNT` (enabled, timing a loss of readiness) and `ST_FIRE` (the request cycle). These transitions apply from any state:
- Enable low goes to `ST_OFF` and reloads the counter.
- Enable high with ready high goes to `ST_WATCH` and reloads the counter.

With enable high and ready low:
- `ST_OFF` or `ST_WATCH` goes to `ST_FIRE` when the reload value is zero. Otherwise it goes to `ST_COUNT` and loads the reload value minus one.
- `ST_COUNT` goes to `ST_FIRE` when the count is zero. Otherwise it decrements and stays in `ST_COUNT`.
- `ST_FIRE` goes to `ST_COUNT` and loads the full reload value. This edge is a recovery edge with no decrement.

Top module: `phy_ready_watchdog`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the request output is low.
- R2: The reload value is R = field × 512, held in a 19-bit counter. For example, a field of 3 gives R = 1536.
- R3: The enable is high and readiness is sampled low on consecutive rising edges, counting from the first such edge. The request is then high in the cycle that follows edge number R+1, and low after every earlier edge.
- R4: The request is never high in two consecutive cycles.
- R5: If readiness stays low after a request, the next request follows R+2 low edges after the edge that raised the previous one. The value of R for this run is taken from the field at the recovery edge.
- R6: A rising edge that samples readiness high gives a low request in the next cycle. Timing then restarts from the full value at the next low edge.
- R7: A rising edge that samples the enable low gives a low request in the next cycle and reloads the counter. Timing then restarts from the full value once the enable is high again.
- R8: A field of zero with the enable set raises the request after the first low edge. If readiness stays low, requests then come after every second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit word clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phy_rdy_i | input | 1 | PHY-ready level |
| wd_en_i | input | 1 | Watchdog enable |
| tmo_field_i | input | 10 | Timeout field; the reload value is this field × 512 |
| phy_rst_req_o | output | 1 | One-cycle PHY-reset request |

## Verification
The case that is hardest to reach is the edge just after a request while readiness is still low. Here the controller must reload without decrementing, and the spacing of the second request depends on it. The stimulus holds readiness low across several timeouts with small fields, so that two requests fall inside one run. It also uses a zero field, where the recovery edge and the firing edge alternate every cycle. Further runs interrupt the count with a one-cycle ready pulse and with a short drop of the enable. Each run checks that timing restarts from the full value.

// File: rtl/prw_pkg.sv
package prw_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_COUNT = 2'd2,
        ST_FIRE  = 2'd3
    } prw_state_t;

endpackage

// File: rtl/prw_reload.sv
module prw_reload #(
    parameter int TMO_W   = 10,
    parameter int GRAN_SH = 9,
    localparam int CNT_W  = TMO_W + GRAN_SH
) (
    input  logic [TMO_W-1:0] tmo_field_i,
    output logic [CNT_W-1:0] rld_o,
    output logic             rld_zero_o
);

    generate
        if (GRAN_SH == 0) begin : g_noshift
            assign rld_o = tmo_field_i;
        end else begin : g_shift
            assign rld_o = {tmo_field_i, {GRAN_SH{1'b0}}};
        end
    endgenerate

    assign rld_zero_o = (tmo_field_i == '0);

endmodule

// File: rtl/prw_counter.sv
module prw_counter #(
    parameter int CNT_W = 19
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ld_i,
    input  logic             ld_m1_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] rld_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= rld_i;
        end else if (ld_m1_i) begin
            cnt_q <= rld_i - CNT_W'(1);
        end else if (dec_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/prw_fsm.sv
module prw_fsm
    import prw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       rdy_i,
    input  logic       cnt_zero_i,
    input  logic       rld_zero_i,
    output logic       ld_o,
    output logic       ld_m1_o,
    output logic       dec_o,
    output logic       req_o,
    output prw_state_t state_o
);

    prw_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // next state and counter control
    always_comb begin
        state_d = state_q;
        ld_o    = 1'b0;
        ld_m1_o = 1'b0;
        dec_o   = 1'b0;
        if (!en_i) begin
            state_d = ST_OFF;
            ld_o    = 1'b1;
        end else if (rdy_i) begin
            state_d = ST_WATCH;
            ld_o    = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF, ST_WATCH: begin
                    if (rld_zero_i) begin
                        state_d = ST_FIRE;
                        ld_o    = 1'b1;
                    end else begin
                        state_d = ST_COUNT;
                        ld_m1_o = 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (cnt_zero_i) begin
                        state_d = ST_FIRE;
                        ld_o    = 1'b1;
                    end else begin
                        dec_o   = 1'b1;
                    end
                end
                ST_FIRE: begin
                    state_d = ST_COUNT;
                    ld_o    = 1'b1;
                end
                default: begin
                    state_d = ST_OFF;
                    ld_o    = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        req_o   = (state_q == ST_FIRE);
        state_o = state_q;
    end

endmodule

// File: rtl/phy_ready_watchdog.sv
module phy_ready_watchdog
    import prw_pkg::*;
#(
    parameter int TMO_W   = 10,
    parameter int GRAN_SH = 9,
    localparam int CNT_W  = TMO_W + GRAN_SH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             phy_rdy_i,
    input  logic             wd_en_i,
    input  logic [TMO_W-1:0] tmo_field_i,
    output logic             phy_rst_req_o
);

    logic [CNT_W-1:0] rld;
    logic             rld_zero;
    logic             cnt_zero;
    logic             ld, ld_m1, dec;
    prw_state_t       state_q;

    prw_reload #(.TMO_W(TMO_W), .GRAN_SH(GRAN_SH)) u_reload (
        .tmo_field_i (tmo_field_i),
        .rld_o       (rld),
        .rld_zero_o  (rld_zero)
    );

    prw_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ld_i    (ld),
        .ld_m1_i (ld_m1),
        .dec_i   (dec),
        .rld_i   (rld),
        .zero_o  (cnt_zero)
    );

    prw_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (wd_en_i),
        .rdy_i      (phy_rdy_i),
        .cnt_zero_i (cnt_zero),
        .rld_zero_i (rld_zero),
        .ld_o       (ld),
        .ld_m1_o    (ld_m1),
        .dec_o      (dec),
        .req_o      (phy_rst_req_o),
        .state_o    (state_q)
    );

endmodule

// File: rtl/prw_checker.sv
module prw_checker
    import prw_pkg::*;
#(
    parameter int TMO_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             phy_rdy_i,
    input logic             wd_en_i,
    input logic [TMO_W-1:0] tmo_field_i,
    input logic             phy_rst_req_o,
    input prw_state_t       state_q
);

    // R4: request lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phy_rst_req_o |=> !phy_rst_req_o);

    // R6: ready sampled high gives no request next cycle
    a_r6_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(phy_rdy_i) |-> !phy_rst_req_o);

    // R7: enable sampled low gives no request next cycle
    a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!wd_en_i) |-> !phy_rst_req_o);

    // R8: zero field fires on first low edge from idle
    a_r8_zero_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past((state_q == ST_OFF || state_q == ST_WATCH) && wd_en_i && !phy_rdy_i
              && tmo_field_i == '0) |-> phy_rst_req_o);

    // R3: a request needs enable high and ready low at the edge before
    a_r3_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phy_rst_req_o |-> $past(wd_en_i && !phy_rdy_i));

endmodule

bind phy_ready_watchdog prw_checker #(.TMO_W(TMO_W)) u_prw_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .phy_rdy_i     (phy_rdy_i),
    .wd_en_i       (wd_en_i),
    .tmo_field_i   (tmo_field_i),
    .phy_rst_req_o (phy_rst_req_o),
    .state_q       (state_q)
);

// File: tb/tb_phy_ready_watchdog.sv
module tb_phy_ready_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rdy = 1'b1;
    logic       en = 1'b0;
    logic [9:0] fld = '0;
    logic       req;

    always #5 clk = ~clk;

    phy_ready_watchdog dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .phy_rdy_i     (rdy),
        .wd_en_i       (en),
        .tmo_field_i   (fld),
        .phy_rst_req_o (req)
    );

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference state, from the requirements
    bit m_active = 0;
    bit m_after  = 0;
    int m_k      = 0;
    int m_r      = 0;

    task automatic step(input bit e, input bit r, input int f, input string tag);
        exp_t it;
        bit   fire;
        @(negedge clk);
        en  = e;
        rdy = r;
        fld = f[9:0];
        fire = 0;
        if (!e || r) begin
            m_active = 0;
        end else if (!m_active) begin
            m_active = 1;
            m_after  = 0;
            m_r      = f * 512;   // R2
            m_k      = 1;
            if (m_k == m_r + 1) begin fire = 1; m_after = 1; m_k = 0; end
        end else begin
            m_k++;
            if (m_after && m_k == 1) m_r = f * 512;
            if (m_k == m_r + (m_after ? 2 : 1)) begin
                fire = 1; m_after = 1; m_k = 0;
            end
        end
        it.exp = fire;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic run(input bit e, input bit r, input int f, input int n, input string tag);
        for (int i = 0; i < n; i++) step(e, r, f, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (req !== it.exp) begin
                n_bad++;
                $display("FAIL %s: req=%b expected %b at %0t", it.tag, req, it.exp, $time);
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: req=%b expected 0 in reset", req);
        end
        rst_n = 1'b1;
        // R1: first cycle after reset, idle inputs
        step(0, 1, 0, "R1");
        // R7: disabled, not ready, long: no request
        run(0, 0, 1, 1200, "R7_disabled");
        // R6: ready high, enabled
        run(1, 1, 1, 10, "R6_ready");
        // R3 + R5: field 1, R=512: requests after edges 513 and 1027
        run(1, 0, 1, 1200, "R3_R5_field1");
        // R6: ready blip restarts timing
        run(1, 1, 1, 2, "R6_ready");
        run(1, 0, 1, 300, "R6_before_blip");
        run(1, 1, 1, 1, "R6_blip");
        run(1, 0, 1, 600, "R6_after_blip");
        // R8: zero field, alternating requests
        run(1, 1, 0, 3, "R8_ready");
        run(1, 0, 0, 9, "R8_zero");
        // R7: enable drop mid-count, field 2 (R=1024)
        run(1, 1, 2, 3, "R7_ready");
        run(1, 0, 2, 700, "R7_partial");
        run(0, 0, 2, 5, "R7_off");
        run(1, 0, 2, 1100, "R7_reenabled");
        // R7: enable dropped just after a request
        run(1, 1, 0, 2, "R7_ready");
        run(1, 0, 0, 1, "R7_fire");
        run(0, 0, 0, 3, "R7_drop_after_fire");
        // R2: field 3 gives R=1536; R4 checked across every vector
        run(1, 1, 3, 2, "R2_ready");
        run(1, 0, 3, 1600, "R2_field3");
        run(1, 1, 3, 3, "R4_tail");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule